// File: doc/BRIEF.md
# Contended CAS Detection Unit

This per-core unit learns which memory words are the targets of compare-and-swap operations that keep failing. It flags the load that opens a new attempt on such a word. Each CAS outcome reports whether it succeeded and which address it used. Failures are counted over a fixed window of cycles. Once the count in the current window has reached a threshold, every further failed CAS records its address in a small fully associative table. Table entries that no CAS touches for a set interval drop out of the table.

Every load address is compared against the table. A hit with no attempt already in flight is a triggering load. The unit pulses a flag, latches the load address as the single active CAS address, and asks the cache to keep that line exclusive, so that requests for it from other cores are refused. A successful CAS to the active address releases everything. If that success is slow to arrive, the hold is dropped after a fixed number of cycles so that other cores can proceed. The active address stays latched until its CAS commits.

The active address is kept by a three-state machine. IDLE means no active address. HOLD means an active address with the line held. LAPSED means an active address whose hold has timed out. There are four transitions:
- IDLE to HOLD on a triggering load.
- HOLD to IDLE on a commit to the active address.
- HOLD to LAPSED when the hold timer expires.
- LAPSED to IDLE on a commit to the active address.

Top module: `cas_hotspot_unit`

## Requirements
- R1: After reset all four outputs are 0, the table holds no entry, the failure count is 0 and the window starts at cycle 0.
- R2: A failed CAS event (`cas_evt_valid`=1, `cas_evt_pass`=0) increments the window failure count, which saturates at THRESH. It also inserts its address, but only if the count taken before this event already equals THRESH, so the earliest failure that can insert is failure number THRESH+1 in the window. The count returns to 0 on the last cycle of every WINDOW-cycle window, counted from reset, and a failure in that cycle is not counted.
- R3: A table entry is removed IDLE_LIMIT cycles after the last CAS event, passing or failing, that carried its address. Loads do not refresh an entry.
- R4: A load (`load_valid`=1) whose address matches a valid entry while `act_valid`=0 is a triggering load. In the next cycle `trig_load` is 1 for exactly one cycle, `act_valid` becomes 1 and `act_addr` equals the load address. An entry written in the same cycle as a load only becomes visible to loads from the following cycle.
- R5: A passing CAS event (`cas_evt_pass`=1) whose address equals `act_addr` while `act_valid`=1 clears `act_valid` in the next cycle. Failing events, and passing events to other addresses, leave it set.
- R6: A table hit while `act_valid`=1 is ignored: `trig_load` stays 0 and `act_addr` is unchanged.
- R7: `hold_line` is 1 from the cycle in which `act_valid` rises and remains 1 until a commit or the timeout. `hold_line` is never 1 while `act_valid` is 0.
- R8: Without a commit, `hold_line` is 1 for exactly HOLD_MAX cycles and then falls while `act_valid` stays 1, which is the LAPSED state. Only a commit ends LAPSED.
- R9: An inserted address goes to the lowest-index invalid entry. If every entry is valid, it goes to the entry with the largest idle age, the lowest index winning a tie. A failed CAS to an address already in the table only resets that entry's age.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cas_evt_valid | input | 1 | A CAS outcome is reported this cycle |
| cas_evt_pass | input | 1 | 1 = the CAS succeeded (commit), 0 = it failed |
| cas_evt_addr | input | ADDR_W | Address the CAS used |
| load_valid | input | 1 | A load is looked up this cycle |
| load_addr | input | ADDR_W | Address of the load |
| trig_load | output | 1 | One-cycle flag: the previous cycle's load started a CAS attempt |
| act_valid | output | 1 | The active CAS address is valid |
| act_addr | output | ADDR_W | Active CAS address, meaningful while act_valid is 1 |
| hold_line | output | 1 | Cache should keep the active line exclusive and refuse other cores |

## Verification
Wrong state in this block hides in the table ages and in the window count. At the ports it appears only at the next load to an affected address: `trig_load` is missing or extra one cycle after that load. That can come many cycles after the fault, so the bench runs a cycle-exact model of the table and compares every cycle. Separate phases bring threshold, ageing, eviction and window-wrap faults to a load within a few cycles. A fault in the state machine shows within one cycle as a mismatch between `hold_line` and `act_valid`, or after exactly HOLD_MAX cycles as a wrong timeout edge.

// File: rtl/cas_hot_pkg.sv
package cas_hot_pkg;

    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_HOLD   = 2'd1,
        ACT_LAPSED = 2'd2
    } act_state_e;

endpackage

// File: rtl/cas_fail_window.sv
module cas_fail_window #(
    parameter int WINDOW = 1024,
    parameter int THRESH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fail_evt,
    output logic over_thresh
);

    localparam int WIN_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam int CNT_W = $clog2(THRESH + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW - 1);
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(THRESH);

    logic [WIN_W-1:0] win_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
            cnt_q <= '0;
        end else if (win_q == WIN_LAST) begin
            win_q <= '0;
            cnt_q <= '0;
        end else begin
            win_q <= win_q + 1'b1;
            if (fail_evt && (cnt_q != CNT_TOP))
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign over_thresh = (cnt_q == CNT_TOP);

endmodule

// File: rtl/cas_addr_table.sv
module cas_addr_table #(
    parameter int ADDR_W     = 32,
    parameter int ENTRIES    = 8,
    parameter int IDLE_LIMIT = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cas_valid,
    input  logic [ADDR_W-1:0] cas_addr,
    input  logic              ins_req,
    input  logic              lookup_valid,
    input  logic [ADDR_W-1:0] lookup_addr,
    output logic              hit
);

    localparam int AGE_W = $clog2(IDLE_LIMIT + 1);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(IDLE_LIMIT - 1);

    logic [ENTRIES-1:0] vld_q;
    logic [ADDR_W-1:0]  tag_q [ENTRIES];
    logic [AGE_W-1:0]   age_q [ENTRIES];

    logic [ENTRIES-1:0] touch;
    logic [ENTRIES-1:0] lmatch;
    logic [IDX_W-1:0]   victim;
    logic [AGE_W-1:0]   best_age;
    logic               have_free;
    logic               do_ins;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign touch[g]  = cas_valid && vld_q[g] && (tag_q[g] == cas_addr);
        assign lmatch[g] = vld_q[g] && (tag_q[g] == lookup_addr);
    end

    assign hit    = lookup_valid && (|lmatch);
    assign do_ins = ins_req && !(|touch);

    always_comb begin
        have_free = 1'b0;
        victim    = '0;
        best_age  = age_q[0];
        for (int i = 0; i < ENTRIES; i++) begin
            if (!vld_q[i] && !have_free) begin
                have_free = 1'b1;
                victim    = IDX_W'(i);
            end
        end
        if (!have_free) begin
            for (int i = 1; i < ENTRIES; i++) begin
                if (age_q[i] > best_age) begin
                    best_age = age_q[i];
                    victim   = IDX_W'(i);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) begin
                vld_q[i] <= 1'b0;
                tag_q[i] <= '0;
                age_q[i] <= '0;
            end else if (do_ins && (victim == IDX_W'(i))) begin
                vld_q[i] <= 1'b1;
                tag_q[i] <= cas_addr;
                age_q[i] <= '0;
            end else if (touch[i]) begin
                age_q[i] <= '0;
            end else if (vld_q[i]) begin
                if (age_q[i] == AGE_LAST)
                    vld_q[i] <= 1'b0;
                else
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cas_active_ctl.sv
module cas_active_ctl
    import cas_hot_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int HOLD_MAX = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_hit,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              commit_valid,
    input  logic [ADDR_W-1:0] commit_addr,
    output logic              trig_load,
    output logic              act_valid,
    output logic [ADDR_W-1:0] act_addr,
    output logic              hold_line
);

    localparam int HOLD_W = $clog2(HOLD_MAX + 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_MAX - 1);

    act_state_e        state_q, state_d;
    logic [HOLD_W-1:0] hold_cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic              trig_q;
    logic              commit;
    logic              start;

    assign commit = commit_valid && (state_q != ACT_IDLE) && (commit_addr == addr_q);
    assign start  = (state_q == ACT_IDLE) && tbl_hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACT_IDLE:   if (tbl_hit) state_d = ACT_HOLD;
            ACT_HOLD:   if (commit) state_d = ACT_IDLE;
                        else if (hold_cnt_q == HOLD_LAST) state_d = ACT_LAPSED;
            ACT_LAPSED: if (commit) state_d = ACT_IDLE;
            default:    state_d = ACT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ACT_IDLE;
            hold_cnt_q <= '0;
            addr_q     <= '0;
            trig_q     <= 1'b0;
        end else begin
            state_q    <= state_d;
            trig_q     <= start;
            hold_cnt_q <= (state_q == ACT_HOLD) ? hold_cnt_q + 1'b1 : '0;
            if (start)
                addr_q <= load_addr;
        end
    end

    always_comb begin
        trig_load = trig_q;
        act_valid = (state_q != ACT_IDLE);
        hold_line = (state_q == ACT_HOLD);
        act_addr  = addr_q;
    end

endmodule

// File: rtl/cas_hotspot_unit.sv
module cas_hotspot_unit #(
    parameter int ADDR_W     = 32,
    parameter int ENTRIES    = 8,
    parameter int WINDOW     = 1024,
    parameter int THRESH     = 4,
    parameter int IDLE_LIMIT = 4096,
    parameter int HOLD_MAX   = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cas_evt_valid,
    input  logic              cas_evt_pass,
    input  logic [ADDR_W-1:0] cas_evt_addr,
    input  logic              load_valid,
    input  logic [ADDR_W-1:0] load_addr,
    output logic              trig_load,
    output logic              act_valid,
    output logic [ADDR_W-1:0] act_addr,
    output logic              hold_line
);

    logic fail_evt;
    logic over_thresh;
    logic tbl_hit;

    assign fail_evt = cas_evt_valid && !cas_evt_pass;

    cas_fail_window #(
        .WINDOW (WINDOW),
        .THRESH (THRESH)
    ) u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .fail_evt    (fail_evt),
        .over_thresh (over_thresh)
    );

    cas_addr_table #(
        .ADDR_W     (ADDR_W),
        .ENTRIES    (ENTRIES),
        .IDLE_LIMIT (IDLE_LIMIT)
    ) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .cas_valid    (cas_evt_valid),
        .cas_addr     (cas_evt_addr),
        .ins_req      (fail_evt && over_thresh),
        .lookup_valid (load_valid),
        .lookup_addr  (load_addr),
        .hit          (tbl_hit)
    );

    cas_active_ctl #(
        .ADDR_W   (ADDR_W),
        .HOLD_MAX (HOLD_MAX)
    ) u_active (
        .clk          (clk),
        .rst_n        (rst_n),
        .tbl_hit      (tbl_hit),
        .load_addr    (load_addr),
        .commit_valid (cas_evt_valid && cas_evt_pass),
        .commit_addr  (cas_evt_addr),
        .trig_load    (trig_load),
        .act_valid    (act_valid),
        .act_addr     (act_addr),
        .hold_line    (hold_line)
    );

endmodule

// File: rtl/cas_hotspot_chk.sv
module cas_hotspot_chk #(
    parameter int ADDR_W   = 32,
    parameter int HOLD_MAX = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cas_evt_valid,
    input logic              cas_evt_pass,
    input logic [ADDR_W-1:0] cas_evt_addr,
    input logic [ADDR_W-1:0] load_addr,
    input logic              trig_load,
    input logic              act_valid,
    input logic [ADDR_W-1:0] act_addr,
    input logic              hold_line
);

    localparam int RUN_W = $clog2(HOLD_MAX + 2);
    localparam logic [RUN_W-1:0] RUN_CAP = RUN_W'(HOLD_MAX);

    logic [RUN_W-1:0] hold_run;

    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_run <= '0;
        else if (hold_line && (hold_run != {RUN_W{1'b1}}))
            hold_run <= hold_run + 1'b1;
        else if (!hold_line)
            hold_run <= '0;
    end

    AST_HOLD_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_line |-> act_valid); // R7

    AST_TRIG_LATCHES_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        trig_load |-> (act_valid && (act_addr == $past(load_addr)))); // R4

    AST_TRIG_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_load |-> !$past(act_valid)); // R6

    AST_ACTIVE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && $past(act_valid)) |-> (act_addr == $past(act_addr))); // R6

    AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && cas_evt_valid && cas_evt_pass && (cas_evt_addr == act_addr))
        |=> !act_valid); // R5

    AST_HOLD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        hold_run <= RUN_CAP); // R8

endmodule

bind cas_hotspot_unit cas_hotspot_chk #(
    .ADDR_W   (ADDR_W),
    .HOLD_MAX (HOLD_MAX)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cas_evt_valid (cas_evt_valid),
    .cas_evt_pass  (cas_evt_pass),
    .cas_evt_addr  (cas_evt_addr),
    .load_addr     (load_addr),
    .trig_load     (trig_load),
    .act_valid     (act_valid),
    .act_addr      (act_addr),
    .hold_line     (hold_line)
);

// File: tb/cas_hotspot_unit_bench.sv
module cas_hotspot_unit_bench;

    localparam int AW    = 16;
    localparam int NENT  = 8;
    localparam int WIN   = 32;
    localparam int THR   = 2;
    localparam int IDLE  = 40;
    localparam int HMAX  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cas_evt_valid = 1'b0;
    logic          cas_evt_pass = 1'b0;
    logic [AW-1:0] cas_evt_addr = '0;
    logic          load_valid = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic          trig_load;
    logic          act_valid;
    logic [AW-1:0] act_addr;
    logic          hold_line;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    int          m_win, m_fail, m_st, m_hc;
    bit          m_v [NENT];
    logic [AW-1:0] m_a [NENT];
    int          m_age [NENT];
    logic [AW-1:0] m_act;
    bit          m_trig;

    always #5 clk = ~clk;

    cas_hotspot_unit #(
        .ADDR_W(AW), .ENTRIES(NENT), .WINDOW(WIN),
        .THRESH(THR), .IDLE_LIMIT(IDLE), .HOLD_MAX(HMAX)
    ) u_cas_hotspot_unit (
        .clk(clk), .rst_n(rst_n),
        .cas_evt_valid(cas_evt_valid), .cas_evt_pass(cas_evt_pass),
        .cas_evt_addr(cas_evt_addr),
        .load_valid(load_valid), .load_addr(load_addr),
        .trig_load(trig_load), .act_valid(act_valid),
        .act_addr(act_addr), .hold_line(hold_line)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, got, exp);
        end
    endtask

    function automatic void model_reset();
        m_win = 0; m_fail = 0; m_st = 0; m_hc = 0; m_act = '0; m_trig = 1'b0;
        for (int i = 0; i < NENT; i++) begin
            m_v[i] = 1'b0; m_a[i] = '0; m_age[i] = 0;
        end
    endfunction

    function automatic void model_step(bit cv, bit cp, logic [AW-1:0] ca,
                                       bit lv, logic [AW-1:0] la);
        bit hit = 1'b0, pres = 1'b0, ins, commit;
        int vic = -1;
        for (int i = 0; i < NENT; i++) begin
            if (lv && m_v[i] && m_a[i] == la) hit = 1'b1;
            if (cv && m_v[i] && m_a[i] == ca) pres = 1'b1;
            if (!m_v[i] && vic < 0) vic = i;
        end
        if (vic < 0) begin
            vic = 0;
            for (int i = 1; i < NENT; i++) if (m_age[i] > m_age[vic]) vic = i;
        end
        ins = cv && !cp && (m_fail >= THR) && !pres;
        commit = cv && cp && (m_st != 0) && (ca == m_act);
        for (int i = 0; i < NENT; i++) begin
            if (ins && i == vic) begin
                m_v[i] = 1'b1; m_a[i] = ca; m_age[i] = 0;
            end else if (cv && m_v[i] && m_a[i] == ca) begin
                m_age[i] = 0;
            end else if (m_v[i]) begin
                if (m_age[i] == IDLE - 1) m_v[i] = 1'b0;
                else m_age[i]++;
            end
        end
        if (m_win == WIN - 1) begin
            m_win = 0; m_fail = 0;
        end else begin
            m_win++;
            if (cv && !cp && m_fail < THR) m_fail++;
        end
        m_trig = (m_st == 0) && hit;
        case (m_st)
            0: if (hit) begin m_st = 1; m_act = la; m_hc = 0; end
            1: if (commit) m_st = 0;
               else if (m_hc == HMAX - 1) m_st = 2;
               else m_hc++;
            default: if (commit) m_st = 0;
        endcase
    endfunction

    task automatic step(input bit cv, input bit cp, input logic [AW-1:0] ca,
                        input bit lv, input logic [AW-1:0] la);
        cas_evt_valid = cv; cas_evt_pass = cp; cas_evt_addr = ca;
        load_valid = lv; load_addr = la;
        model_step(cv, cp, ca, lv, la);
        @(posedge clk);
        @(negedge clk);
        chk("R4 trig_load", 32'(trig_load), 32'(m_trig));
        chk("R5 act_valid", 32'(act_valid), 32'(m_st != 0));
        chk("R7 hold_line", 32'(hold_line), 32'(m_st == 1));
        if (m_st != 0) chk("R4 act_addr", 32'(act_addr), 32'(m_act));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 0, '0, 0, '0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cas_evt_valid = 1'b0; load_valid = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        chk("R1 trig_load reset", 32'(trig_load), 0);
        chk("R1 act_valid reset", 32'(act_valid), 0);
        chk("R1 hold_line reset", 32'(hold_line), 0);

        // R2: THRESH failures alone do not insert, the next one does
        step(1, 0, 16'h100, 0, '0);
        step(1, 0, 16'h100, 0, '0);
        step(0, 0, '0, 1, 16'h100);
        chk("R2 no insert at threshold", 32'(trig_load), 0);
        step(1, 0, 16'h100, 0, '0);
        step(0, 0, '0, 1, 16'h100);
        chk("R4 trig after insert", 32'(trig_load), 1);
        chk("R4 act_addr latched", 32'(act_addr), 32'h100);
        chk("R7 hold with active", 32'(hold_line), 1);
        step(1, 1, 16'h100, 0, '0);
        chk("R5 commit clears", 32'(act_valid), 0);

        // R9: nine insertions, the oldest entry is evicted
        do_reset();
        step(1, 0, 16'h200, 0, '0);
        step(1, 0, 16'h200, 0, '0);
        for (int k = 0; k <= NENT; k++) step(1, 0, 16'(16'h200 + k), 0, '0);
        step(0, 0, '0, 1, 16'h200);
        chk("R9 oldest evicted", 32'(trig_load), 0);
        step(0, 0, '0, 1, 16'h201);
        chk("R9 survivor hits", 32'(trig_load), 1);

        // R6 / R8 / R5 on the active address 0x201
        step(0, 0, '0, 1, 16'h202);
        chk("R6 hit ignored trig", 32'(trig_load), 0);
        chk("R6 hit ignored addr", 32'(act_addr), 32'h201);
        idle(HMAX - 2);
        chk("R8 hold last cycle", 32'(hold_line), 1);
        idle(1);
        chk("R8 hold timed out", 32'(hold_line), 0);
        chk("R8 active kept", 32'(act_valid), 1);
        step(1, 1, 16'h202, 0, '0);
        chk("R5 other addr keeps", 32'(act_valid), 1);
        step(1, 0, 16'h201, 0, '0);
        chk("R5 failure keeps", 32'(act_valid), 1);
        step(1, 1, 16'h201, 0, '0);
        chk("R5 commit from lapsed", 32'(act_valid), 0);

        // R3: idle entry ages out
        do_reset();
        for (int k = 0; k <= THR; k++) step(1, 0, 16'h300, 0, '0);
        idle(IDLE + 2);
        step(0, 0, '0, 1, 16'h300);
        chk("R3 idle entry removed", 32'(trig_load), 0);

        // R2: window boundary clears the count
        do_reset();
        step(1, 0, 16'h400, 0, '0);
        step(1, 0, 16'h400, 0, '0);
        idle(WIN);
        step(1, 0, 16'h400, 0, '0);
        step(0, 0, '0, 1, 16'h400);
        chk("R2 window reset count", 32'(trig_load), 0);

        // random traffic against the model
        do_reset();
        for (int k = 0; k < 3000; k++) begin
            bit cv = ($urandom % 2) == 0;
            bit cp = ($urandom % 10) < 3;
            bit lv = ($urandom % 5) < 2;
            logic [AW-1:0] ca = 16'(16'h500 + ($urandom % 12));
            logic [AW-1:0] la = (m_st != 0 && ($urandom % 3) == 0) ? m_act
                                : 16'(16'h500 + ($urandom % 12));
            if (m_st != 0 && ($urandom % 4) == 0) ca = m_act;
            step(cv, cp, ca, lv, la);
        end

        done = 1'b1;
        finish_up();
    end

    initial begin
        #1ms;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_up();
        end
    end

endmodule